// File: doc/BRIEF.md
# Serial Control Word Loader

This block receives configuration words over a three-wire serial link (a serial clock, a data line and a load strobe) and distributes each word to one of four holding registers inside a frequency synthesizer's digital section. Bits are shifted most significant first into a 21-bit register. When the load strobe rises, the two lowest bits of that register choose the destination and the remaining 19 bits are copied into it.

All three serial lines are asynchronous to the system clock. They are brought into the system domain through a synchronizer chain, and the rising edges of the serial clock and the load strobe are detected there. The four destinations are the reference divider register, the feedback divider register (two fields), the function register and the initialization register. Each destination has a one-cycle update pulse. A 3-bit output-source select is taken from the function register and is also given as a one-hot decode.

Top module: `scw_loader`

## Requirements
- R1: During and after reset, every holding register output, the output-source select and all four update pulses are zero, and `mux_onehot_o` is 1 (source 0).
- R2: Each rising serial clock edge shifts the data line into bit 0 while the older bits move toward the top. Only the last 21 bits shifted before a load are used, and the first of them lands in bit 20.
- R3: A load with word bits [1:0] = 00 sets `r_div_o` to word bits [15:2] and leaves the other registers unchanged.
- R4: A load with word bits [1:0] = 01 sets `n_a_o` to word bits [6:2] and `n_b_o` to word bits [19:7] and leaves the other registers unchanged.
- R5: A load with word bits [1:0] = 10 sets `func_o` to word bits [20:2] and leaves the other registers unchanged. `mux_sel_o` always equals `func_o[4:2]`, which is word bits [6:4].
- R6: A load with word bits [1:0] = 11 sets both `init_o` and `func_o` to word bits [20:2].
- R7: A transfer happens only on a rising edge of the load line. Shifting without a load changes no register, and holding the load line high causes no second transfer.
- R8: Each transfer raises the update pulse of every register it writes for exactly one system clock. The pulses rise in the same cycle that the register changes, and no other pulse is raised.
- R9: `mux_onehot_o` has exactly one bit set, at the position given by `mux_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_load_i | input | 1 | Load strobe; its rising edge triggers a transfer |
| r_div_o | output | 14 | Reference divider register |
| n_a_o | output | 5 | Feedback divider A field |
| n_b_o | output | 13 | Feedback divider B field |
| func_o | output | 19 | Function register |
| init_o | output | 19 | Initialization register |
| mux_sel_o | output | 3 | Output-source select taken from the function register |
| mux_onehot_o | output | 8 | One-hot decode of `mux_sel_o` |
| r_upd_o | output | 1 | Reference register update pulse |
| n_upd_o | output | 1 | Feedback register update pulse |
| func_upd_o | output | 1 | Function register update pulse |
| init_upd_o | output | 1 | Initialization register update pulse |

## Verification
The assertions assume the serial lines change slowly compared with the system clock. The serial clock must stay high and stay low for longer than the synchronizer depth, and the load line must rise only after the last serial clock edge has settled. Under that assumption two transfers can never fall in adjacent cycles. The stimulus holds every serial level for at least three system clocks, and it changes the data line only while the serial clock is low.

// File: rtl/scw_pkg.sv
package scw_pkg;

   // Destination codes carried in the two lowest word bits
   typedef enum logic [1:0] {
      DEST_REF  = 2'b00,
      DEST_FB   = 2'b01,
      DEST_FUNC = 2'b10,
      DEST_INIT = 2'b11
   } dest_e;

   localparam int unsigned DEF_WORD_W = 21;
   localparam int unsigned DEF_CTRL_W = 2;

   // Bundle of update pulses
   typedef struct packed {
      logic init_upd;
      logic func_upd;
      logic fb_upd;
      logic ref_upd;
   } upd_t;

endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
         if (gs == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gs] <= '0;
               else        chain_q[gs] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gs] <= '0;
               else        chain_q[gs] <= chain_q[gs-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/scw_shifter.sv
module scw_shifter #(
   parameter int unsigned WORD_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o
);

   generate
      if (WORD_W < 3) begin : g_bad_width
         $error("scw_shifter: WORD_W too small");
      end
   endgenerate

   logic [WORD_W-1:0] shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          shreg_q <= '0;
      else if (shift_en_i) shreg_q <= {shreg_q[WORD_W-2:0], bit_i};
   end

   assign word_o = shreg_q;

endmodule

// File: rtl/scw_latch_bank.sv
module scw_latch_bank
   import scw_pkg::*;
#(
   parameter int unsigned WORD_W = 21,
   parameter int unsigned CTRL_W = 2,
   parameter int unsigned R_W    = 14,
   parameter int unsigned A_W    = 5,
   parameter int unsigned B_W    = 13,
   localparam int unsigned PAY_W = WORD_W - CTRL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [R_W-1:0]    ref_q_o,
   output logic [A_W-1:0]    a_q_o,
   output logic [B_W-1:0]    b_q_o,
   output logic [PAY_W-1:0]  func_q_o,
   output logic [PAY_W-1:0]  init_q_o,
   output upd_t              upd_o
);

   generate
      if (CTRL_W != 2) begin : g_bad_ctrl
         $error("scw_latch_bank: CTRL_W must be 2");
      end
      if (R_W > PAY_W) begin : g_bad_ref
         $error("scw_latch_bank: R_W exceeds payload");
      end
      if (A_W + B_W > PAY_W) begin : g_bad_fb
         $error("scw_latch_bank: A_W + B_W exceeds payload");
      end
   endgenerate

   dest_e            dest;
   logic [PAY_W-1:0] payload;

   assign dest    = dest_e'(word_i[CTRL_W-1:0]);
   assign payload = word_i[WORD_W-1:CTRL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q_o  <= '0;
         a_q_o    <= '0;
         b_q_o    <= '0;
         func_q_o <= '0;
         init_q_o <= '0;
         upd_o    <= '0;
      end else begin
         upd_o <= '0;
         if (load_i) begin
            unique case (dest)
               DEST_REF: begin
                  ref_q_o        <= payload[R_W-1:0];
                  upd_o.ref_upd  <= 1'b1;
               end
               DEST_FB: begin
                  a_q_o          <= payload[A_W-1:0];
                  b_q_o          <= payload[A_W+B_W-1:A_W];
                  upd_o.fb_upd   <= 1'b1;
               end
               DEST_FUNC: begin
                  func_q_o       <= payload;
                  upd_o.func_upd <= 1'b1;
               end
               DEST_INIT: begin
                  init_q_o       <= payload;
                  func_q_o       <= payload;
                  upd_o.init_upd <= 1'b1;
                  upd_o.func_upd <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/scw_mux_decode.sv
module scw_mux_decode #(
   parameter int unsigned PAY_W   = 19,
   parameter int unsigned MUX_POS = 2,
   parameter int unsigned MUX_W   = 3,
   localparam int unsigned MUX_N  = 1 << MUX_W
) (
   input  logic [PAY_W-1:0] func_i,
   output logic [MUX_W-1:0] sel_o,
   output logic [MUX_N-1:0] onehot_o
);

   generate
      if (MUX_POS + MUX_W > PAY_W) begin : g_bad_field
         $error("scw_mux_decode: select field outside function register");
      end
   endgenerate

   assign sel_o = func_i[MUX_POS +: MUX_W];

   generate
      for (genvar gd = 0; gd < MUX_N; gd++) begin : g_dec
         assign onehot_o[gd] = (sel_o == MUX_W'(gd));
      end
   endgenerate

endmodule

// File: rtl/scw_loader.sv
module scw_loader
   import scw_pkg::*;
#(
   parameter int unsigned WORD_W      = DEF_WORD_W,
   parameter int unsigned CTRL_W      = DEF_CTRL_W,
   parameter int unsigned R_W         = 14,
   parameter int unsigned A_W         = 5,
   parameter int unsigned B_W         = 13,
   parameter int unsigned MUX_POS     = 2,
   parameter int unsigned MUX_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned PAY_W      = WORD_W - CTRL_W,
   localparam int unsigned MUX_N      = 1 << MUX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_data_i,
   input  logic              ser_load_i,
   output logic [R_W-1:0]    r_div_o,
   output logic [A_W-1:0]    n_a_o,
   output logic [B_W-1:0]    n_b_o,
   output logic [PAY_W-1:0]  func_o,
   output logic [PAY_W-1:0]  init_o,
   output logic [MUX_W-1:0]  mux_sel_o,
   output logic [MUX_N-1:0]  mux_onehot_o,
   output logic              r_upd_o,
   output logic              n_upd_o,
   output logic              func_upd_o,
   output logic              init_upd_o
);

   // Bit order inside the synchronized bundle
   localparam int unsigned IDX_CLK  = 0;
   localparam int unsigned IDX_DATA = 1;
   localparam int unsigned IDX_LOAD = 2;

   logic [2:0]        lines_s;
   logic              clk_prev_q;
   logic              load_prev_q;
   logic              shift_en;
   logic              load_en;
   logic [WORD_W-1:0] word;
   upd_t              upd;

   // All three lines pass through the same depth, so data stays aligned with the clock
   scw_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (3)
   ) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ser_load_i, ser_data_i, ser_clk_i}),
      .sync_o  (lines_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_prev_q  <= 1'b0;
         load_prev_q <= 1'b0;
      end else begin
         clk_prev_q  <= lines_s[IDX_CLK];
         load_prev_q <= lines_s[IDX_LOAD];
      end
   end

   assign shift_en = lines_s[IDX_CLK]  & ~clk_prev_q;
   assign load_en  = lines_s[IDX_LOAD] & ~load_prev_q;

   scw_shifter #(
      .WORD_W (WORD_W)
   ) shift_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en_i (shift_en),
      .bit_i      (lines_s[IDX_DATA]),
      .word_o     (word)
   );

   scw_latch_bank #(
      .WORD_W (WORD_W),
      .CTRL_W (CTRL_W),
      .R_W    (R_W),
      .A_W    (A_W),
      .B_W    (B_W)
   ) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_en),
      .word_i   (word),
      .ref_q_o  (r_div_o),
      .a_q_o    (n_a_o),
      .b_q_o    (n_b_o),
      .func_q_o (func_o),
      .init_q_o (init_o),
      .upd_o    (upd)
   );

   scw_mux_decode #(
      .PAY_W   (PAY_W),
      .MUX_POS (MUX_POS),
      .MUX_W   (MUX_W)
   ) dec_i (
      .func_i   (func_o),
      .sel_o    (mux_sel_o),
      .onehot_o (mux_onehot_o)
   );

   assign r_upd_o    = upd.ref_upd;
   assign n_upd_o    = upd.fb_upd;
   assign func_upd_o = upd.func_upd;
   assign init_upd_o = upd.init_upd;

endmodule

// File: rtl/scw_loader_chk.sv
module scw_loader_chk #(
   parameter int unsigned R_W     = 14,
   parameter int unsigned A_W     = 5,
   parameter int unsigned B_W     = 13,
   parameter int unsigned PAY_W   = 19,
   parameter int unsigned MUX_POS = 2,
   parameter int unsigned MUX_W   = 3,
   parameter int unsigned MUX_N   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [R_W-1:0]   r_div_o,
   input logic [A_W-1:0]   n_a_o,
   input logic [B_W-1:0]   n_b_o,
   input logic [PAY_W-1:0] func_o,
   input logic [PAY_W-1:0] init_o,
   input logic [MUX_W-1:0] mux_sel_o,
   input logic [MUX_N-1:0] mux_onehot_o,
   input logic             r_upd_o,
   input logic             n_upd_o,
   input logic             func_upd_o,
   input logic             init_upd_o
);

   assert_ref_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !r_upd_o |-> $stable(r_div_o));

   assert_fb_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !n_upd_o |-> ($stable(n_a_o) && $stable(n_b_o)));

   assert_func_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !func_upd_o |-> $stable(func_o));

   assert_init_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !init_upd_o |-> $stable(init_o));

   assert_init_sets_func_R6: assert property (@(posedge clk) disable iff (!rst_n)
      init_upd_o |-> (func_upd_o && func_o == init_o));

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (r_upd_o || n_upd_o || func_upd_o) |=> !(r_upd_o || n_upd_o || func_upd_o));

   assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({r_upd_o, n_upd_o, func_upd_o}) <= 1);

   assert_sel_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mux_sel_o == func_o[MUX_POS +: MUX_W]);

   assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(mux_onehot_o) && mux_onehot_o[mux_sel_o]);

endmodule

bind scw_loader scw_loader_chk #(
   .R_W     (R_W),
   .A_W     (A_W),
   .B_W     (B_W),
   .PAY_W   (PAY_W),
   .MUX_POS (MUX_POS),
   .MUX_W   (MUX_W),
   .MUX_N   (MUX_N)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .r_div_o      (r_div_o),
   .n_a_o        (n_a_o),
   .n_b_o        (n_b_o),
   .func_o       (func_o),
   .init_o       (init_o),
   .mux_sel_o    (mux_sel_o),
   .mux_onehot_o (mux_onehot_o),
   .r_upd_o      (r_upd_o),
   .n_upd_o      (n_upd_o),
   .func_upd_o   (func_upd_o),
   .init_upd_o   (init_upd_o)
);

// File: tb/scw_loader_tb_top.sv
`timescale 1ns/1ps
module scw_loader_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_data = 1'b0;
   logic        ser_load = 1'b0;
   logic [13:0] r_div;
   logic [4:0]  n_a;
   logic [12:0] n_b;
   logic [18:0] func;
   logic [18:0] init;
   logic [2:0]  mux_sel;
   logic [7:0]  mux_onehot;
   logic        r_upd, n_upd, func_upd, init_upd;

   int n_checks = 0;
   int n_fail   = 0;
   int cnt_r = 0, cnt_n = 0, cnt_f = 0, cnt_i = 0;

   always #10 clk = ~clk;

   scw_loader dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ser_clk_i    (ser_clk),
      .ser_data_i   (ser_data),
      .ser_load_i   (ser_load),
      .r_div_o      (r_div),
      .n_a_o        (n_a),
      .n_b_o        (n_b),
      .func_o       (func),
      .init_o       (init),
      .mux_sel_o    (mux_sel),
      .mux_onehot_o (mux_onehot),
      .r_upd_o      (r_upd),
      .n_upd_o      (n_upd),
      .func_upd_o   (func_upd),
      .init_upd_o   (init_upd)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (r_upd)    cnt_r++;
         if (n_upd)    cnt_n++;
         if (func_upd) cnt_f++;
         if (init_upd) cnt_i++;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      ser_data = b;
      wait_neg(3);
      ser_clk = 1'b1;
      wait_neg(3);
      ser_clk = 1'b0;
      wait_neg(1);
   endtask

   task automatic send_word(input logic [20:0] w, input int prefix);
      for (int i = 0; i < prefix; i++) shift_bit(i[0]);
      for (int i = 20; i >= 0; i--) shift_bit(w[i]);
      wait_neg(4);
   endtask

   task automatic load(input int hold);
      ser_load = 1'b1;
      wait_neg(hold);
      ser_load = 1'b0;
      wait_neg(6);
   endtask

   task automatic t_reset();
      check("R1", "r_div", 32'(r_div), 0);
      check("R1", "n_a",   32'(n_a), 0);
      check("R1", "n_b",   32'(n_b), 0);
      check("R1", "func",  32'(func), 0);
      check("R1", "init",  32'(init), 0);
      check("R1", "mux_onehot", 32'(mux_onehot), 1);
      check("R1", "pulses", 32'({r_upd, n_upd, func_upd, init_upd}), 0);
   endtask

   task automatic t_ref_load();
      int r0 = cnt_r, n0 = cnt_n, f0 = cnt_f, i0 = cnt_i;
      // junk prefix bits must fall off the top (R2)
      send_word({5'h15, 14'h2A5C, 2'b00}, 5);
      load(4);
      check("R3", "r_div", 32'(r_div), 32'h2A5C);
      check("R2", "prefix ignored, n_b", 32'(n_b), 0);
      check("R3", "func untouched", 32'(func), 0);
      check("R8", "ref pulse count", 32'(cnt_r - r0), 1);
      check("R8", "other pulses", 32'((cnt_n - n0) + (cnt_f - f0) + (cnt_i - i0)), 0);
   endtask

   task automatic t_fb_load();
      int n0 = cnt_n;
      send_word({1'b1, 13'h1ABC, 5'h13, 2'b01}, 0);
      load(4);
      check("R4", "n_a", 32'(n_a), 32'h13);
      check("R4", "n_b", 32'(n_b), 32'h1ABC);
      check("R4", "r_div untouched", 32'(r_div), 32'h2A5C);
      check("R8", "fb pulse count", 32'(cnt_n - n0), 1);
   endtask

   task automatic t_func_load();
      logic [18:0] p = 19'h5A3D6;
      int f0 = cnt_f;
      send_word({p, 2'b10}, 0);
      load(4);
      check("R5", "func", 32'(func), 32'(p));
      check("R5", "mux_sel", 32'(mux_sel), 32'(p[4:2]));
      check("R9", "mux_onehot", 32'(mux_onehot), 32'(1) << p[4:2]);
      check("R5", "init untouched", 32'(init), 0);
      check("R8", "func pulse count", 32'(cnt_f - f0), 1);
   endtask

   task automatic t_init_load();
      logic [18:0] p = 19'h31F6A;
      int f0 = cnt_f, i0 = cnt_i, r0 = cnt_r;
      send_word({p, 2'b11}, 0);
      load(4);
      check("R6", "init", 32'(init), 32'(p));
      check("R6", "func follows", 32'(func), 32'(p));
      check("R6", "init pulse", 32'(cnt_i - i0), 1);
      check("R6", "func pulse", 32'(cnt_f - f0), 1);
      check("R8", "ref not pulsed", 32'(cnt_r - r0), 0);
   endtask

   task automatic t_load_edge();
      int r0 = cnt_r;
      send_word({5'h00, 14'h0777, 2'b00}, 0);
      check("R7", "no load yet", 32'(r_div), 32'h2A5C);
      check("R7", "no pulse yet", 32'(cnt_r - r0), 0);
      load(40);
      check("R7", "loaded once", 32'(r_div), 32'h0777);
      check("R7", "held high one transfer", 32'(cnt_r - r0), 1);
      // Shift a new word with load low: nothing moves
      send_word({5'h1F, 14'h1111, 2'b00}, 0);
      check("R7", "shift without load", 32'(r_div), 32'h0777);
   endtask

   task automatic t_mux_sweep();
      for (int v = 0; v < 8; v++) begin
         logic [18:0] p = 19'h40001 | (19'(v) << 2);
         send_word({p, 2'b10}, 0);
         load(3);
         check("R9", "sweep onehot", 32'(mux_onehot), 32'(1) << v);
         check("R5", "sweep sel", 32'(mux_sel), 32'(v));
      end
   endtask

   initial begin
      wait_neg(3);
      t_reset();
      rst_n = 1'b1;
      wait_neg(3);
      t_reset();
      t_ref_load();
      t_fb_load();
      t_func_load();
      t_init_load();
      t_load_edge();
      t_mux_sweep();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule